// File: doc/BRIEF.md
# Grouped Reply Interrupt Coalescer

This block sits between a stream of completion replies and the interrupt vectors that announce them to the host. Each reply carries the index of the reply queue it targets. Queues are bundled into fixed groups of consecutive indices. Replies to one group build up in a single pending window. The window is released as one interrupt when one of these happens:
- the pending count reaches a programmed depth;
- a programmed timeout, counted in 500 ns ticks from the first reply of the window, runs out;
- a reply arrives for a queue in a different group.

A per-queue enable decides whether replies to a queue are coalesced at all. Replies to non-coalescing queues are announced without delay, so latency-sensitive queues and throughput queues can share one controller.

Each interrupt is a one-cycle pulse on `irq_valid`. It carries the vector (the queue of the latest reply in the released window) and the number of replies it delivers. Configuration comes from plain register inputs that the surrounding logic holds steady.

Top module: `reply_coalescer`

## Requirements
- R1: After reset, and for as long as reset is held, `irq_valid` is low and no window is pending. No interrupt follows reset unless a new reply arrives.
- R2: Queue q belongs to group q / GROUP_SIZE, which is bits [6:3] of `rep_queue` at the default sizes. Coalesced replies to queues of one group add to the same pending window.
- R3: A reply to a queue outside the pending group releases the old window in the next cycle. The interrupt carries the old window's latest queue and its count. The new reply opens a fresh window.
- R4: When a coalesced reply brings the pending count to `cfg_depth`, an interrupt follows in the next cycle. It carries that reply's queue and a count equal to the depth. A depth of 0 acts as 1.
- R5: A window that is not released otherwise raises its interrupt (cfg_timeout+1) ticks after the edge that opened it. One tick is CLK_MHZ/2 cycles (500 ns).
- R6: A reply to a queue whose `cfg_coal_en` bit is 0 raises an interrupt in the next cycle, with its own queue as vector. The count is 1 when no window is pending. When a window of the same group is pending, the count is that window's count plus 1.
- R7: A non-coalesced reply that meets a pending window of another group releases the old window in the next cycle and raises its own count-1 interrupt in the cycle after.
- R8: When a release for any reason coincides with a new reply, one interrupt covers only the old window. The new reply starts a fresh window with its own timeout.
- R9: Every interrupt reports a non-zero count equal to the replies it delivers. Its vector is the queue of the latest reply in the window.
- R10: Later replies to the pending group do not restart the timeout, which is measured from the first reply of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rep_valid | input | 1 | A reply is presented this cycle |
| rep_queue | input | 7 | Target reply queue of the reply |
| cfg_depth | input | 8 | Replies per window that force a release (0 acts as 1) |
| cfg_timeout | input | 16 | Timeout in 500 ns ticks, minus one |
| cfg_coal_en | input | 128 | Per-queue coalescing enable, bit q for queue q |
| irq_valid | output | 1 | One-cycle interrupt pulse |
| irq_vector | output | 7 | Vector (queue) of the interrupt |
| irq_count | output | 8 | Replies delivered by the interrupt |

## Verification
The hardest case to reach from the ports is a release that coincides exactly with a new reply. The timeout edge falls on a single cycle, tens of cycles after the window opened. The bench counts cycles from the acceptance edge and times a second reply to land on that edge. It then checks that the old window goes out alone and that the new reply's window times out a full period later. The deferred interrupt of a non-coalesced reply that meets another group's window is reached in the vector walk, by placing such a reply directly after two coalesced ones.

// File: rtl/rc_pkg.sv
package rc_pkg;

   // Length of one timeout tick in nanoseconds.
   localparam int RC_TICK_NS = 500;

   // Clock cycles per timeout tick for a clock given in MHz.
   function automatic int rc_tick_cycles(input int clk_mhz);
      return (clk_mhz * RC_TICK_NS) / 1000;
   endfunction

   // Decision taken on one clock edge by the window tracker.
   typedef enum logic [1:0] {
      RC_HOLD  = 2'd0,  // no reply, no release
      RC_SPILL = 2'd1,  // old window released, reply (if any) opens a new one
      RC_JOIN  = 2'd2,  // reply joins the pending window
      RC_START = 2'd3   // reply meets an empty tracker
   } rc_step_e;

endpackage

// File: rtl/rc_tick_timer.sv
module rc_tick_timer #(
   parameter int CLK_MHZ = 100,
   parameter int TMO_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [TMO_W-1:0] cfg_timeout,
   output logic             tmo_hit
);
   import rc_pkg::*;

   localparam int TICK_CYC = rc_tick_cycles(CLK_MHZ);
   localparam int PRE_W    = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

   logic             tick;
   logic [TMO_W-1:0] ticks_q;

   generate
      if (TICK_CYC == 1) begin : g_no_prescale
         assign tick = 1'b1;
      end else begin : g_prescale
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n || restart || !run)
               pre_q <= '0;
            else if (pre_q == PRE_W'(TICK_CYC - 1))
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == PRE_W'(TICK_CYC - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || restart || !run)
         ticks_q <= '0;
      else if (tick)
         ticks_q <= ticks_q + 1'b1;
   end

   assign tmo_hit = run && tick && (ticks_q == cfg_timeout);

endmodule

// File: rtl/rc_window_tracker.sv
module rc_window_tracker #(
   parameter int NUM_QUEUES = 128,
   parameter int GROUP_SIZE = 8,
   parameter int DEPTH_W    = 8,
   localparam int QW        = $clog2(NUM_QUEUES),
   localparam int GW        = $clog2(GROUP_SIZE),
   localparam int GRP_W     = QW - GW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rep_valid,
   input  logic [QW-1:0]         rep_queue,
   input  logic [NUM_QUEUES-1:0] cfg_coal_en,
   input  logic [DEPTH_W-1:0]    cfg_depth,
   input  logic                  tmo_hit,
   output logic                  win_act,
   output logic [GRP_W-1:0]      win_grp,
   output logic [DEPTH_W-1:0]    win_cnt,
   output logic                  win_urg,
   output logic                  win_open,
   output logic                  fl_valid,
   output logic [QW-1:0]         fl_vector,
   output logic [DEPTH_W-1:0]    fl_count
);
   import rc_pkg::*;

   logic               act_q, urg_q;
   logic [GRP_W-1:0]   grp_q;
   logic [QW-1:0]      vec_q;
   logic [DEPTH_W-1:0] cnt_q;

   logic               act_d, urg_d;
   logic [GRP_W-1:0]   grp_d;
   logic [QW-1:0]      vec_d;
   logic [DEPTH_W-1:0] cnt_d;

   logic [GRP_W-1:0]   rq_grp;
   logic               coal, single, spill;
   logic [DEPTH_W-1:0] depth_eff;
   logic [DEPTH_W:0]   join_cnt;
   rc_step_e           step;

   always_comb begin
      rq_grp    = rep_queue[QW-1:GW];
      coal      = cfg_coal_en[rep_queue];
      depth_eff = (cfg_depth == '0) ? DEPTH_W'(1) : cfg_depth;
      single    = !coal || (depth_eff == DEPTH_W'(1));
      join_cnt  = {1'b0, cnt_q} + 1'b1;
      spill     = act_q && (urg_q || tmo_hit || (rep_valid && (rq_grp != grp_q)));

      if (spill)                 step = RC_SPILL;
      else if (act_q && rep_valid) step = RC_JOIN;
      else if (rep_valid)        step = RC_START;
      else                       step = RC_HOLD;
   end

   always_comb begin
      act_d     = act_q;
      urg_d     = urg_q;
      grp_d     = grp_q;
      vec_d     = vec_q;
      cnt_d     = cnt_q;
      win_open  = 1'b0;
      fl_valid  = 1'b0;
      fl_vector = vec_q;
      fl_count  = cnt_q;
      unique case (step)
         RC_SPILL: begin
            fl_valid = 1'b1;
            act_d    = rep_valid;
            if (rep_valid) begin
               win_open = 1'b1;
               grp_d    = rq_grp;
               vec_d    = rep_queue;
               cnt_d    = DEPTH_W'(1);
               urg_d    = single;
            end else begin
               urg_d    = 1'b0;
               cnt_d    = '0;
            end
         end
         RC_JOIN: begin
            if (!coal || (join_cnt >= {1'b0, depth_eff})) begin
               fl_valid  = 1'b1;
               fl_vector = rep_queue;
               fl_count  = join_cnt[DEPTH_W-1:0];
               act_d     = 1'b0;
               cnt_d     = '0;
            end else begin
               vec_d = rep_queue;
               cnt_d = join_cnt[DEPTH_W-1:0];
            end
         end
         RC_START: begin
            if (single) begin
               fl_valid  = 1'b1;
               fl_vector = rep_queue;
               fl_count  = DEPTH_W'(1);
            end else begin
               win_open = 1'b1;
               act_d    = 1'b1;
               urg_d    = 1'b0;
               grp_d    = rq_grp;
               vec_d    = rep_queue;
               cnt_d    = DEPTH_W'(1);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         urg_q <= 1'b0;
         grp_q <= '0;
         vec_q <= '0;
         cnt_q <= '0;
      end else begin
         act_q <= act_d;
         urg_q <= urg_d;
         grp_q <= grp_d;
         vec_q <= vec_d;
         cnt_q <= cnt_d;
      end
   end

   assign win_act = act_q;
   assign win_grp = grp_q;
   assign win_cnt = cnt_q;
   assign win_urg = urg_q;

endmodule

// File: rtl/rc_irq_stage.sv
module rc_irq_stage #(
   parameter int QW      = 7,
   parameter int DEPTH_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fl_valid,
   input  logic [QW-1:0]      fl_vector,
   input  logic [DEPTH_W-1:0] fl_count,
   output logic               irq_valid,
   output logic [QW-1:0]      irq_vector,
   output logic [DEPTH_W-1:0] irq_count
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_vector <= '0;
         irq_count  <= '0;
      end else begin
         irq_valid <= fl_valid;
         if (fl_valid) begin
            irq_vector <= fl_vector;
            irq_count  <= fl_count;
         end
      end
   end
endmodule

// File: rtl/reply_coalescer.sv
module reply_coalescer #(
   parameter int NUM_QUEUES = 128,
   parameter int GROUP_SIZE = 8,
   parameter int CLK_MHZ    = 100,
   parameter int DEPTH_W    = 8,
   parameter int TMO_W      = 16,
   localparam int QW        = $clog2(NUM_QUEUES),
   localparam int GW        = $clog2(GROUP_SIZE),
   localparam int GRP_W     = QW - GW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rep_valid,
   input  logic [QW-1:0]         rep_queue,
   input  logic [DEPTH_W-1:0]    cfg_depth,
   input  logic [TMO_W-1:0]      cfg_timeout,
   input  logic [NUM_QUEUES-1:0] cfg_coal_en,
   output logic                  irq_valid,
   output logic [QW-1:0]         irq_vector,
   output logic [DEPTH_W-1:0]    irq_count
);

   initial begin
      assert ((1 << QW) == NUM_QUEUES)
         else $error("NUM_QUEUES must be a power of two");
      assert ((1 << GW) == GROUP_SIZE && GROUP_SIZE >= 2)
         else $error("GROUP_SIZE must be a power of two, at least 2");
      assert (NUM_QUEUES >= 2 * GROUP_SIZE)
         else $error("need at least two groups");
      assert (CLK_MHZ >= 2 && (CLK_MHZ % 2) == 0)
         else $error("CLK_MHZ must be even so a tick is whole cycles");
      assert (DEPTH_W >= 2 && TMO_W >= 1)
         else $error("counter widths too small");
   end

   logic               win_act, win_urg, win_open, tmo_hit;
   logic [GRP_W-1:0]   win_grp;
   logic [DEPTH_W-1:0] win_cnt;
   logic               fl_valid;
   logic [QW-1:0]      fl_vector;
   logic [DEPTH_W-1:0] fl_count;

   rc_tick_timer #(
      .CLK_MHZ (CLK_MHZ),
      .TMO_W   (TMO_W)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (win_open),
      .run         (win_act),
      .cfg_timeout (cfg_timeout),
      .tmo_hit     (tmo_hit)
   );

   rc_window_tracker #(
      .NUM_QUEUES (NUM_QUEUES),
      .GROUP_SIZE (GROUP_SIZE),
      .DEPTH_W    (DEPTH_W)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .rep_valid   (rep_valid),
      .rep_queue   (rep_queue),
      .cfg_coal_en (cfg_coal_en),
      .cfg_depth   (cfg_depth),
      .tmo_hit     (tmo_hit),
      .win_act     (win_act),
      .win_grp     (win_grp),
      .win_cnt     (win_cnt),
      .win_urg     (win_urg),
      .win_open    (win_open),
      .fl_valid    (fl_valid),
      .fl_vector   (fl_vector),
      .fl_count    (fl_count)
   );

   rc_irq_stage #(
      .QW      (QW),
      .DEPTH_W (DEPTH_W)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fl_valid   (fl_valid),
      .fl_vector  (fl_vector),
      .fl_count   (fl_count),
      .irq_valid  (irq_valid),
      .irq_vector (irq_vector),
      .irq_count  (irq_count)
   );

endmodule

// File: rtl/reply_coalescer_chk.sv
module reply_coalescer_chk #(
   parameter int NUM_QUEUES = 128,
   parameter int GROUP_SIZE = 8,
   parameter int DEPTH_W    = 8,
   localparam int QW        = $clog2(NUM_QUEUES),
   localparam int GW        = $clog2(GROUP_SIZE),
   localparam int GRP_W     = QW - GW
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rep_valid,
   input logic [QW-1:0]         rep_queue,
   input logic [DEPTH_W-1:0]    cfg_depth,
   input logic [NUM_QUEUES-1:0] cfg_coal_en,
   input logic                  irq_valid,
   input logic [QW-1:0]         irq_vector,
   input logic [DEPTH_W-1:0]    irq_count,
   input logic                  win_act,
   input logic [GRP_W-1:0]      win_grp,
   input logic [DEPTH_W-1:0]    win_cnt,
   input logic                  win_urg,
   input logic                  tmo_hit
);
   logic               other_grp, coal;
   logic [DEPTH_W-1:0] depth_eff;

   assign other_grp = rep_queue[QW-1:GW] != win_grp;
   assign coal      = cfg_coal_en[rep_queue];
   assign depth_eff = (cfg_depth == '0) ? DEPTH_W'(1) : cfg_depth;

   // R1: the first cycle out of reset carries no interrupt.
   assert_quiet_reset_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> !irq_valid);

   // R9: every interrupt delivers at least one reply.
   assert_nonzero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_count != '0));

   // R3: a reply to another group releases the old window next cycle.
   assert_group_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_act && rep_valid && other_grp) |=>
         (irq_valid && irq_vector[QW-1:GW] == $past(win_grp) &&
          irq_count == $past(win_cnt)));

   // R6: a non-coalesced reply with nothing pending goes out next cycle.
   assert_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_act && rep_valid && !coal) |=>
         (irq_valid && irq_vector == $past(rep_queue) && irq_count == DEPTH_W'(1)));

   // R7: a non-coalesced reply meeting another group follows one cycle later.
   assert_deferred_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_act && rep_valid && other_grp && !coal) |=> ##1
         (irq_valid && irq_vector == $past(rep_queue, 2) && irq_count == DEPTH_W'(1)));

   // R4: reaching the depth within a group releases that group next cycle.
   assert_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (win_act && rep_valid && !other_grp && !win_urg && !tmo_hit && coal &&
       ({1'b0, win_cnt} + 1'b1 >= {1'b0, depth_eff})) |=>
         (irq_valid && {1'b0, irq_count} == {1'b0, $past(win_cnt)} + 1'b1));

endmodule

bind reply_coalescer reply_coalescer_chk #(
   .NUM_QUEUES (NUM_QUEUES),
   .GROUP_SIZE (GROUP_SIZE),
   .DEPTH_W    (DEPTH_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .rep_valid   (rep_valid),
   .rep_queue   (rep_queue),
   .cfg_depth   (cfg_depth),
   .cfg_coal_en (cfg_coal_en),
   .irq_valid   (irq_valid),
   .irq_vector  (irq_vector),
   .irq_count   (irq_count),
   .win_act     (win_act),
   .win_grp     (win_grp),
   .win_cnt     (win_cnt),
   .win_urg     (win_urg),
   .tmo_hit     (tmo_hit)
);

// File: tb/reply_coalescer_tb_top.sv
module reply_coalescer_tb_top;

   localparam int NQ   = 128;
   localparam int TICK = 50;   // 500 ns at 100 MHz
   localparam int NROW = 17;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         rep_valid;
   logic [6:0]   rep_queue;
   logic [7:0]   cfg_depth;
   logic [15:0]  cfg_timeout;
   logic [NQ-1:0] cfg_coal_en;
   logic         irq_valid;
   logic [6:0]   irq_vector;
   logic [7:0]   irq_count;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   reply_coalescer dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .rep_valid   (rep_valid),
      .rep_queue   (rep_queue),
      .cfg_depth   (cfg_depth),
      .cfg_timeout (cfg_timeout),
      .cfg_coal_en (cfg_coal_en),
      .irq_valid   (irq_valid),
      .irq_vector  (irq_vector),
      .irq_count   (irq_count)
   );

   // Row: {req[3:0], valid, queue[6:0], exp_irq, exp_vec[6:0], exp_cnt[7:0]}
   // Depth 4, long timeout, queue 20 (group 2) not coalesced.
   localparam logic [27:0] TBL [NROW] = '{
      {4'd2, 1'b1, 7'd33,  1'b0, 7'd0,   8'd0},  // R2 group 4 opens
      {4'd2, 1'b1, 7'd34,  1'b0, 7'd0,   8'd0},  // R2 joins
      {4'd2, 1'b1, 7'd35,  1'b0, 7'd0,   8'd0},  // R2 joins
      {4'd4, 1'b1, 7'd36,  1'b1, 7'd36,  8'd4},  // R4 depth reached
      {4'd4, 1'b1, 7'd37,  1'b0, 7'd0,   8'd0},  // R4 fresh window
      {4'd3, 1'b1, 7'd40,  1'b1, 7'd37,  8'd1},  // R3 group change
      {4'd3, 1'b1, 7'd41,  1'b0, 7'd0,   8'd0},  // R3 joins new group
      {4'd7, 1'b1, 7'd20,  1'b1, 7'd41,  8'd2},  // R7 old window first
      {4'd7, 1'b0, 7'd0,   1'b1, 7'd20,  8'd1},  // R7 deferred own irq
      {4'd6, 1'b1, 7'd20,  1'b1, 7'd20,  8'd1},  // R6 direct
      {4'd6, 1'b1, 7'd16,  1'b0, 7'd0,   8'd0},  // R6 coalesced in group 2
      {4'd6, 1'b1, 7'd20,  1'b1, 7'd20,  8'd2},  // R6 merge same group
      {4'd2, 1'b1, 7'd127, 1'b0, 7'd0,   8'd0},  // R2 top queue
      {4'd9, 1'b1, 7'd0,   1'b1, 7'd127, 8'd1},  // R9 vector of last group
      {4'd2, 1'b1, 7'd7,   1'b0, 7'd0,   8'd0},  // R2 queue 7 with queue 0
      {4'd9, 1'b1, 7'd8,   1'b1, 7'd7,   8'd2},  // R9 latest queue 7
      {4'd1, 1'b0, 7'd0,   1'b0, 7'd0,   8'd0}   // R1 idle
   };

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n     = 1'b0;
      rep_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(input logic [6:0] q);
      rep_valid = 1'b1;
      rep_queue = q;
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      finish_run();
   end

   initial begin
      int quiet_bad;
      rst_n       = 1'b0;
      rep_valid   = 1'b0;
      rep_queue   = '0;
      cfg_depth   = 8'd4;
      cfg_timeout = 16'd1000;
      cfg_coal_en = '1;
      cfg_coal_en[20] = 1'b0;

      // R1: during and after reset
      repeat (3) @(negedge clk);
      check("R1", "irq during reset", int'(irq_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "irq after reset", int'(irq_valid), 0);

      // Vector walk
      for (int i = 0; i < NROW; i++) begin
         string tag;
         tag       = $sformatf("R%0d", int'(TBL[i][27:24]));
         rep_valid = TBL[i][23];
         rep_queue = TBL[i][22:16];
         @(negedge clk);
         rep_valid = 1'b0;
         check(tag, $sformatf("row %0d irq", i), int'(irq_valid), int'(TBL[i][15]));
         if (TBL[i][15]) begin
            check(tag, $sformatf("row %0d vector", i), int'(irq_vector), int'(TBL[i][14:8]));
            check(tag, $sformatf("row %0d count", i), int'(irq_count), int'(TBL[i][7:0]));
         end
      end

      // R1: reset clears the window left pending by the walk
      cfg_timeout = 16'd0;
      do_reset();
      quiet_bad = 0;
      for (int i = 0; i < 3 * TICK; i++) begin
         @(negedge clk);
         if (irq_valid) quiet_bad++;
      end
      check("R1", "irqs after reset with pending cleared", quiet_bad, 0);

      // R5 / R10: timeout 2 -> 3 ticks from the opening edge; a join at +60
      cfg_timeout = 16'd2;
      cfg_depth   = 8'd8;
      send(7'd50);
      @(negedge clk);
      rep_valid = 1'b0;
      quiet_bad = 0;
      for (int i = 1; i <= 3 * TICK; i++) begin
         if (i == 60) send(7'd51);
         @(negedge clk);
         rep_valid = 1'b0;
         if (i < 3 * TICK) begin
            if (irq_valid) quiet_bad++;
         end else begin
            check("R5", "timeout irq", int'(irq_valid), 1);
            check("R10", "timeout count with join", int'(irq_count), 2);
            check("R9", "timeout vector latest", int'(irq_vector), 51);
         end
      end
      check("R10", "no early irq before timeout", quiet_bad, 0);

      // R8: new reply lands on the timeout edge of the old window
      cfg_timeout = 16'd0;
      send(7'd50);
      @(negedge clk);
      rep_valid = 1'b0;
      quiet_bad = 0;
      for (int i = 1; i <= 2 * TICK; i++) begin
         if (i == TICK) send(7'd52);
         @(negedge clk);
         rep_valid = 1'b0;
         if (i == TICK) begin
            check("R8", "merged release irq", int'(irq_valid), 1);
            check("R8", "merged release count", int'(irq_count), 1);
            check("R8", "merged release vector", int'(irq_vector), 50);
         end else if (i == 2 * TICK) begin
            check("R8", "fresh window timeout irq", int'(irq_valid), 1);
            check("R8", "fresh window vector", int'(irq_vector), 52);
         end else if (irq_valid) begin
            quiet_bad++;
         end
      end
      check("R8", "stray irqs around merge", quiet_bad, 0);

      // R4: depth 0 acts as 1
      cfg_depth = 8'd0;
      repeat (2) @(negedge clk);
      send(7'd3);
      @(negedge clk);
      rep_valid = 1'b0;
      check("R4", "depth0 irq", int'(irq_valid), 1);
      check("R4", "depth0 count", int'(irq_count), 1);
      check("R4", "depth0 vector", int'(irq_vector), 3);
      @(negedge clk);
      check("R4", "depth0 single pulse", int'(irq_valid), 0);

      finish_run();
   end

endmodule